// File: doc/BRIEF.md
# Scatter-Gather Segment Descriptor Queue

This block sits between a register-write port and a DMA engine. Software describes a transfer as a list of memory segments. For each segment it first stages a 64-bit segment address and then writes a command word. The command write turns the staged address and the command into one queue entry. The engine sees the oldest entry at its output. It pulses `seg_complete` when it has finished that segment, and the entry then leaves the queue.

Each entry gives the engine four things:
- the segment address;
- the segment length in 64-bit words (the command stores it as words minus one);
- a direction bit;
- an endian-swap bit.

Each entry also carries an interrupt-suppress bit. Software sets it on every segment except the last, so a whole list raises a single completion interrupt.

A configuration write controls the queue. With the clear bit set, the write empties the queue and disables it. With the clear bit low, the write enables the queue. The number of pending entries is always visible on `q_count`. Pushes the queue cannot take set a sticky overflow flag. Misaligned segment addresses set a sticky alignment-error flag.

Top module: `sgq_top`

## Requirements
- R1: After reset the queue is empty (`q_count` = 0, `seg_valid` = 0), disabled (`q_enabled` = 0), and both `ovf_flag` and `align_err` are 0.
- R2: A write with `wr_sel` = 0 stages `wr_data` as the segment address. If `wr_data[2:0]` is non-zero, `align_err` becomes 1, nothing is staged, and a following command write pushes no entry.
- R3: A write with `wr_sel` = 1 and an aligned address staged pushes one entry and raises `q_count` by one. The write uses up the staged address, so a second command write with no new address write pushes nothing.
- R4: The command word is laid out as follows:
  - bits [19:0] hold the length in words minus one;
  - bit 20 is the direction (`seg_write`);
  - bit 21 is endian swap (`seg_swap`);
  - bit 22 suppresses the completion interrupt.

  `seg_len_words` equals field + 1, so an all-ones field gives 1048576.
- R5: The queue holds 16 entries. A push made while 16 entries are pending is dropped and sets `ovf_flag` to 1, even if a pop happens in the same cycle.
- R6: A push made while the queue is disabled is dropped and sets `ovf_flag` to 1.
- R7: A write with `wr_sel` = 2 behaves according to `wr_data[16]`:
  - with bit 16 set, it empties the queue, disables it, and clears `ovf_flag` and `align_err`;
  - with bit 16 clear, it enables the queue;
  - all other bits are ignored.
- R8: Entries leave in push order. A `seg_complete` pulse while `seg_valid` is 1 removes the head entry and lowers `q_count` by one. A `seg_complete` pulse while the queue is empty has no effect.
- R9: `done_irq` is 1 in the cycle where `seg_complete` removes a head entry whose suppress bit is 0. It is 0 in every other cycle.
- R10: A push and a pop in the same cycle leave `q_count` unchanged, and the next entry becomes the head.
- R11: A write with `wr_sel` = 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target of the write: 0 = address, 1 = command, 2 = config, 3 = none |
| wr_data | input | 64 | Write data |
| seg_complete | input | 1 | One-cycle pulse from the engine: head segment finished |
| seg_valid | output | 1 | A head entry is available |
| seg_addr | output | 64 | Head segment address |
| seg_len_words | output | 21 | Head segment length in 64-bit words |
| seg_write | output | 1 | Head segment direction |
| seg_swap | output | 1 | Head segment endian swap |
| done_irq | output | 1 | Completion interrupt pulse |
| q_count | output | 5 | Number of pending entries |
| q_enabled | output | 1 | Queue enable state |
| ovf_flag | output | 1 | Sticky: a push was dropped |
| align_err | output | 1 | Sticky: a misaligned address was written |

## Verification
The assertions assume that `seg_complete` is a single-cycle pulse and that at most one register write arrives per cycle. The queue count assertions also rely on a clear never coinciding with a push, which holds because the single write port cannot carry a config write and a command write together. The stimulus drives one write at a time, only on falling edges, and always releases `seg_complete` after one cycle. The only overlap of push and pop is the deliberate one that exercises R10.

// File: rtl/sgq_pkg.sv
package sgq_pkg;
  localparam int ADDR_W        = 64;
  localparam int SIZE_W        = 20;
  localparam int CMD_DIR_BIT   = 20;
  localparam int CMD_SWAP_BIT  = 21;
  localparam int CMD_NOIRQ_BIT = 22;
  localparam int CFG_CLR_BIT   = 16;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [SIZE_W-1:0] size_m1;
    logic              wr;
    logic              swap;
    logic              noirq;
  } seg_entry_t;

  // segment length in words from the minus-one field
  function automatic logic [SIZE_W:0] seg_words(input logic [SIZE_W-1:0] f);
    return {1'b0, f} + {{SIZE_W{1'b0}}, 1'b1};
  endfunction

  function automatic logic addr_aligned(input logic [ADDR_W-1:0] a);
    return a[2:0] == 3'b000;
  endfunction

  function automatic seg_entry_t build_entry(input logic [ADDR_W-1:0] a,
                                             input logic [63:0] cmd);
    seg_entry_t e;
    e.addr    = a;
    e.size_m1 = cmd[SIZE_W-1:0];
    e.wr      = cmd[CMD_DIR_BIT];
    e.swap    = cmd[CMD_SWAP_BIT];
    e.noirq   = cmd[CMD_NOIRQ_BIT];
    return e;
  endfunction
endpackage

// File: rtl/sgq_regs.sv
module sgq_regs
  import sgq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [63:0]       wr_data,
  input  logic              q_full,
  output logic              push_ok,
  output seg_entry_t        push_ent,
  output logic              clr_ev,
  output logic              q_en,
  output logic              ovf,
  output logic              aerr
);
  logic [ADDR_W-1:0] stg_addr;
  logic              stg_vld;
  logic              addr_wr, cmd_wr, cfg_wr;
  logic              misalign_ev, push_req, drop_ev;

  assign addr_wr     = wr_en && (wr_sel == SEL_ADDR);
  assign cmd_wr      = wr_en && (wr_sel == SEL_CMD);
  assign cfg_wr      = wr_en && (wr_sel == SEL_CFG);
  assign misalign_ev = addr_wr && !addr_aligned(wr_data);
  assign push_req    = cmd_wr && stg_vld;
  assign push_ok     = push_req && q_en && !q_full;
  assign drop_ev     = push_req && !push_ok;
  assign clr_ev      = cfg_wr && wr_data[CFG_CLR_BIT];
  assign push_ent    = build_entry(stg_addr, wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_addr <= '0;
      stg_vld  <= 1'b0;
      q_en     <= 1'b0;
      ovf      <= 1'b0;
      aerr     <= 1'b0;
    end else begin
      if (addr_wr) begin
        stg_addr <= wr_data;
        stg_vld  <= addr_aligned(wr_data);
      end else if (cmd_wr) begin
        stg_vld  <= 1'b0;
      end
      if (cfg_wr) q_en <= !wr_data[CFG_CLR_BIT];
      if (clr_ev) begin
        ovf  <= 1'b0;
        aerr <= 1'b0;
      end else begin
        if (drop_ev)     ovf  <= 1'b1;
        if (misalign_ev) aerr <= 1'b1;
      end
    end
  end

  AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> ovf); // R5
  AST_MISALIGN_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_ev |=> !push_req); // R2
  AST_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_ev |=> aerr); // R2
endmodule

// File: rtl/sgq_ring.sv
module sgq_ring
  import sgq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  seg_entry_t       push_ent,
  input  logic             pop_req,
  input  logic             clr,
  output seg_entry_t       head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             nonempty
);
  seg_entry_t       slot_q [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign nonempty = (count != '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign pop      = pop_req && nonempty;
  assign head     = slot_q[rptr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               slot_q[g] <= '0;
      else if (push && (wptr == PTR_W'(g)))     slot_q[g] <= push_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= ptr_next(wptr);
      if (pop)  rptr <= ptr_next(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R5
  AST_POP_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !clr) |=> count == $past(count) - 1'b1); // R8
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0); // R7
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !clr) |=> count == $past(count)); // R10
endmodule

// File: rtl/sgq_top.sv
module sgq_top
  import sgq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [63:0]       wr_data,
  input  logic              seg_complete,
  output logic              seg_valid,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [SIZE_W:0]   seg_len_words,
  output logic              seg_write,
  output logic              seg_swap,
  output logic              done_irq,
  output logic [CNT_W-1:0]  q_count,
  output logic              q_enabled,
  output logic              ovf_flag,
  output logic              align_err
);
  seg_entry_t push_ent, head;
  logic       push_ok, clr_ev, q_full;

  sgq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .q_full(q_full), .push_ok(push_ok),
    .push_ent(push_ent), .clr_ev(clr_ev), .q_en(q_enabled),
    .ovf(ovf_flag), .aerr(align_err)
  );

  sgq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .push_ent(push_ent),
    .pop_req(seg_complete), .clr(clr_ev), .head(head),
    .count(q_count), .full(q_full), .nonempty(seg_valid)
  );

  assign seg_addr      = head.addr;
  assign seg_len_words = seg_words(head.size_m1);
  assign seg_write     = head.wr;
  assign seg_swap      = head.swap;
  assign done_irq      = seg_complete && seg_valid && !head.noirq;

  AST_IRQ_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !push_ok && !clr_ev) |=> q_count == $past(q_count) - 1'b1); // R9
  AST_DISABLED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_enabled && !seg_complete) |=> $stable(q_count)); // R6
endmodule

// File: tb/sim_sgq_top.sv
module sim_sgq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [63:0] wr_data = '0;
  logic        seg_complete = 1'b0;
  logic        seg_valid, seg_write, seg_swap, done_irq;
  logic [63:0] seg_addr;
  logic [20:0] seg_len_words;
  logic [4:0]  q_count;
  logic        q_enabled, ovf_flag, align_err;

  int n_chk = 0;
  int n_bad = 0;
  logic irq_seen;

  always #4 clk = ~clk;

  sgq_top u0 (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic pop_one();
    @(negedge clk);
    seg_complete = 1'b1;
    #1 irq_seen = done_irq;
    @(negedge clk);
    seg_complete = 1'b0;
  endtask

  function automatic logic [19:0] e_size(input int i);
    return (i == 15) ? 20'hFFFFF : 20'((i * i * 37 + i * 5) % 1048576);
  endfunction
  function automatic logic [63:0] e_addr(input int i);
    return 64'h4000_0000 + 64'(i) * 64'h88;
  endfunction
  function automatic logic [63:0] e_cmd(input int i);
    return {41'd0, (i % 3 != 0), i[1], i[0], e_size(i)};
  endfunction

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count", 64'(q_count), 0);
    check("R1 valid", 64'(seg_valid), 0);
    check("R1 enabled", 64'(q_enabled), 0);
    check("R1 flags", 64'({ovf_flag, align_err}), 0);

    wr(2'd0, 64'h100); wr(2'd1, 64'h0);
    check("R6 dropped count", 64'(q_count), 0);
    check("R6 overflow", 64'(ovf_flag), 1);

    wr(2'd2, 64'h1_0000);
    check("R7 clear flags", 64'(ovf_flag), 0);
    check("R7 disabled", 64'(q_enabled), 0);
    wr(2'd2, 64'hFFFF_FFFF_FFFE_FFFF);
    check("R7 enable", 64'(q_enabled), 1);

    for (int i = 0; i < 16; i++) begin
      wr(2'd0, e_addr(i)); wr(2'd1, e_cmd(i));
      check("R3 push count", 64'(q_count), 64'(i + 1));
    end
    wr(2'd0, 64'h9000); wr(2'd1, 64'h5);
    check("R5 full count", 64'(q_count), 16);
    check("R5 overflow", 64'(ovf_flag), 1);

    for (int i = 0; i < 16; i++) begin
      check("R8 valid", 64'(seg_valid), 1);
      check("R8 order addr", seg_addr, e_addr(i));
      check("R4 length", 64'(seg_len_words), 64'(e_size(i)) + 1);
      check("R4 dir", 64'(seg_write), 64'(i % 2));
      check("R4 swap", 64'(seg_swap), 64'((i / 2) % 2));
      pop_one();
      check("R9 irq", 64'(irq_seen), 64'(i % 3 == 0));
      check("R8 count", 64'(q_count), 64'(15 - i));
    end
    pop_one();
    check("R8 empty pop count", 64'(q_count), 0);
    check("R9 empty no irq", 64'(irq_seen), 0);

    wr(2'd2, 64'h1_0000); wr(2'd2, 64'h0);
    for (int b = 1; b < 8; b++) begin
      wr(2'd0, 64'h2000 | 64'(b));
      check("R2 align flag", 64'(align_err), 1);
      wr(2'd1, 64'h3);
      check("R2 no push", 64'(q_count), 0);
    end

    wr(2'd0, 64'h3000); wr(2'd1, 64'h0);
    check("R3 single push", 64'(q_count), 1);
    wr(2'd1, 64'h0);
    check("R3 staged consumed", 64'(q_count), 1);
    check("R3 no overflow", 64'(ovf_flag), 0);

    wr(2'd3, 64'h1_0000);
    check("R11 count", 64'(q_count), 1);
    check("R11 enabled", 64'(q_enabled), 1);

    wr(2'd0, 64'h5000);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 64'h40_0001; seg_complete = 1'b1;
    #1 irq_seen = done_irq;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3; seg_complete = 1'b0;
    check("R9 irq on push-pop", 64'(irq_seen), 1);
    check("R10 count held", 64'(q_count), 1);
    check("R10 new head", seg_addr, 64'h5000);
    check("R10 new length", 64'(seg_len_words), 2);

    wr(2'd2, 64'h1_0000);
    check("R7 clear count", 64'(q_count), 0);
    check("R7 clear valid", 64'(seg_valid), 0);
    check("R7 clear disables", 64'(q_enabled), 0);
    check("R7 clear align", 64'(align_err), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule